// File: doc/BRIEF.md
# Transmit Dominant Timeout Monitor

This block sits between a CAN protocol controller and a transceiver's line driver. It watches the already synchronized transmit data line. When a node gets stuck driving dominant (TXD low), the bus would otherwise be held dominant forever. The monitor prevents that.

A falling edge of TXD in normal mode arms a cycle counter. If TXD stays low for the whole timeout window, the monitor raises a fault flag and withdraws the gated driver enable. The bus is then free for the other nodes. The receive path is never touched, so the node still sees bus traffic during the fault. The fault is cleared by the first recessive (high) sample of TXD, not by a reset.

The timeout is given as a clock-cycle count. It has to cover eleven dominant bit times at the lowest bit rate the system supports, and a companion parameter states that bit time in cycles.

Top module: `txd_dom_guard`

## Requirements
- R1: `drv_en_o` is 0 whenever `norm_mode_i` is 0. When `norm_mode_i` is 1 and `fault_o` is 0, `drv_en_o` is 1 in the same cycle.
- R2: The timer arms only on a falling edge: TXD sampled 1 at one clock edge and 0 at the next, with `norm_mode_i` = 1 at the second edge. TXD that is already low when normal mode starts never arms the timer.
- R3: The falling-edge sample counts as the first low sample. `fault_o` becomes 1 after the TIMEOUT_CYC-th consecutive low sample in normal mode, and `drv_en_o` drops in that same cycle.
- R4: If TXD rises before the timeout, no fault is raised. The next falling edge starts a fresh count from one.
- R5: `fault_o` clears at the first clock edge at which TXD is sampled 1, whatever the mode. While TXD stays low, nothing but reset clears it.
- R6: When `norm_mode_i` goes to 0, the timer count is discarded. An existing fault and the withdrawn enable are kept through the mode change until TXD is high.
- R7: TIMEOUT_CYC must be at least 11 × MIN_BIT_CYC (eleven dominant bits at the slowest rate) and at least 2.
- R8: After reset, `fault_o` = 0, the timer is idle, and the previous TXD sample is taken as recessive (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Synchronized transmit data, 0 = dominant |
| norm_mode_i | input | 1 | 1 while the transceiver is in normal mode |
| drv_en_o | output | 1 | Gated line-driver enable |
| fault_o | output | 1 | Dominant-timeout fault flag |

## Verification
Suppose the timer counts wrongly or arms on the wrong event. Then the fault appears one or more cycles early or late relative to the TIMEOUT_CYC-th low sample, or it appears with no falling edge at all, and `fault_o` and `drv_en_o` show this in the very cycle it happens. A lost hold state shows up as `fault_o` dropping while TXD is still low across a mode change. A count that is not cleared on leaving normal mode shows up as a fault after re-entry without a fresh falling edge. The directed cases place samples exactly at TIMEOUT_CYC−1 and TIMEOUT_CYC. Random low runs around the limit compare every cycle against a bench model.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

  // Worst-case run of dominant bits a legal frame can produce.
  localparam int unsigned MAX_DOM_BITS = 11;

  // True when the sample being taken is the limit-th low sample,
  // given the number of low samples already counted.
  function automatic logic run_expired(input int unsigned counted,
                                       input int unsigned limit);
    return (counted + 1) >= limit;
  endfunction

  // Smallest legal timeout in cycles for a given bit time in cycles.
  function automatic int unsigned min_timeout(input int unsigned bit_cyc);
    return MAX_DOM_BITS * bit_cyc;
  endfunction

endpackage

// File: rtl/tdg_edge_det.sv
module tdg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  output logic fall_o
);
  logic txd_prev;

  // Previous sample resets to recessive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_prev <= 1'b1;
    else        txd_prev <= txd_i;
  end

  assign fall_o = txd_prev & ~txd_i;
endmodule

// File: rtl/tdg_timer.sv
module tdg_timer #(
  parameter int unsigned TIMEOUT_CYC = 400000,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          run_i,
  output logic          expire_o,
  output logic          armed_o,
  output logic [CW-1:0] cnt_o
);
  import tdg_pkg::*;

  logic          armed;
  logic [CW-1:0] cnt;

  assign expire_o = armed & run_i & run_expired(32'(cnt), TIMEOUT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!run_i) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm_i) begin
      armed <= 1'b1;
      cnt   <= CW'(1);
    end else if (expire_o) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed) begin
      cnt   <= cnt + CW'(1);
    end
  end

  assign armed_o = armed;
  assign cnt_o   = cnt;
endmodule

// File: rtl/tdg_fault_hold.sv
module tdg_fault_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault_o <= 1'b0;
    else if (clr_i) fault_o <= 1'b0;
    else if (set_i) fault_o <= 1'b1;
  end
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned TIMEOUT_CYC = 400000,
  parameter int unsigned MIN_BIT_CYC = 25000,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic norm_mode_i,
  output logic drv_en_o,
  output logic fault_o
);
  // Named internal events for the checker.
  logic          fall_ev;
  logic          arm_ev;
  logic          run_ev;
  logic          expire_ev;
  logic          armed;
  logic [CW-1:0] tmr_cnt;

  tdg_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .txd_i  (txd_i),
    .fall_o (fall_ev)
  );

  assign arm_ev = fall_ev & norm_mode_i;
  assign run_ev = norm_mode_i & ~txd_i;

  tdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_ev),
    .run_i    (run_ev),
    .expire_o (expire_ev),
    .armed_o  (armed),
    .cnt_o    (tmr_cnt)
  );

  tdg_fault_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (expire_ev),
    .clr_i   (txd_i),
    .fault_o (fault_o)
  );

  assign drv_en_o = norm_mode_i & ~fault_o;
endmodule

// File: rtl/tdg_chk.sv
module tdg_chk #(
  parameter int unsigned TIMEOUT_CYC = 400000,
  parameter int unsigned MIN_BIT_CYC = 25000,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd_i,
  input logic          norm_mode_i,
  input logic          drv_en_o,
  input logic          fault_o,
  input logic          fall_ev,
  input logic          armed,
  input logic [CW-1:0] tmr_cnt
);
  import tdg_pkg::*;

  // Independent low-run counter for the timeout window check.
  logic [CW-1:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  chk_run <= '0;
    else if (txd_i || !norm_mode_i)              chk_run <= '0;
    else if (chk_run == CW'(TIMEOUT_CYC))        chk_run <= chk_run;
    else if (fall_ev || chk_run != '0)           chk_run <= chk_run + CW'(1);
  end

  initial begin
    a_r7_timeout_span: assert (TIMEOUT_CYC >= min_timeout(MIN_BIT_CYC) && TIMEOUT_CYC >= 2);
  end

  a_r1_off_outside_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_mode_i |-> !drv_en_o);

  a_r3_fault_gates_driver: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !drv_en_o);

  a_r3_fault_at_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (chk_run == CW'(TIMEOUT_CYC)));

  a_r2_arm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && norm_mode_i) |=> (armed && tmr_cnt == CW'(1)));

  a_r5_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_i && fault_o) |=> !fault_o);

  a_r6_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !txd_i) |=> fault_o);

  a_r6_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_mode_i |=> (!armed && tmr_cnt == '0));
endmodule

bind txd_dom_guard tdg_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .MIN_BIT_CYC(MIN_BIT_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txd_i       (txd_i),
  .norm_mode_i (norm_mode_i),
  .drv_en_o    (drv_en_o),
  .fault_o     (fault_o),
  .fall_ev     (fall_ev),
  .armed       (armed),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/txd_dom_guard_tb.sv
module txd_dom_guard_tb;
  localparam int unsigned T = 40;
  localparam int unsigned B = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1;
  logic norm = 1'b0;
  logic drv_en, fault;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(T), .MIN_BIT_CYC(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .norm_mode_i(norm),
    .drv_en_o(drv_en), .fault_o(fault)
  );

  // Bench model: length of the current armed low run and the fault state.
  bit m_prev = 1'b1;
  int m_run  = 0;
  bit m_fault = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 1'b1; m_run = 0; m_fault = 1'b0;
    end else begin
      if (txd) begin
        m_fault = 1'b0; m_run = 0;
      end else if (!norm) begin
        m_run = 0;
      end else if (m_run > 0 || m_prev) begin
        m_run = m_run + 1;
        if (m_run >= T) begin m_fault = 1'b1; m_run = 0; end
      end
      m_prev = txd;
    end
  end

  function automatic bit exp_enable(input bit n, input bit f);
    return n && !f;
  endfunction

  function automatic bit span_ok(input int unsigned t, input int unsigned b);
    return t >= 11 * b && t >= 2;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Drive at a negedge, let one rising edge pass, return at the next negedge.
  task automatic cyc(input logic t, input logic n);
    txd = t; norm = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycn(input logic t, input logic n, input int k);
    for (int i = 0; i < k; i++) cyc(t, n);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int seg;
    logic rt, rn;
    seed = $urandom(20240611);
    @(negedge clk); @(negedge clk);
    // R8 reset state
    chk("R8 fault after reset", fault, 1'b0);
    chk("R1 enable off in standby", drv_en, 1'b0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1);
    chk("R1 enable on in normal", drv_en, 1'b1);
    chk("R7 timeout span", logic'(span_ok(T, B)), 1'b1);

    // R3 exact window
    cycn(1'b0, 1'b1, T - 1);
    chk("R3 no fault at T-1", fault, 1'b0);
    chk("R3 enable held at T-1", drv_en, 1'b1);
    cyc(1'b0, 1'b1);
    chk("R3 fault at T", fault, 1'b1);
    chk("R3 enable dropped", drv_en, 1'b0);
    cycn(1'b0, 1'b1, 5);
    chk("R5 fault held while low", fault, 1'b1);
    // R5 clear on high
    cyc(1'b1, 1'b1);
    chk("R5 cleared on high", fault, 1'b0);
    chk("R5 enable restored", drv_en, 1'b1);

    // R4 rise before timeout restarts count
    cycn(1'b0, 1'b1, T - 1);
    cyc(1'b1, 1'b1);
    cycn(1'b0, 1'b1, T - 1);
    chk("R4 fresh count no fault", fault, 1'b0);
    cyc(1'b1, 1'b1);

    // R2 low already present when entering normal
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    cycn(1'b0, 1'b1, 2 * T);
    chk("R2 no arm without fall in normal", fault, 1'b0);
    chk("R2 enable kept", drv_en, 1'b1);
    cyc(1'b1, 1'b1);

    // R6 fault held through mode change
    cycn(1'b0, 1'b1, T);
    chk("R6 fault raised", fault, 1'b1);
    cycn(1'b0, 1'b0, 3);
    chk("R6 fault held in standby", fault, 1'b1);
    chk("R1 enable off in standby", drv_en, 1'b0);
    cycn(1'b0, 1'b1, 3);
    chk("R6 fault held back in normal", fault, 1'b1);
    chk("R6 enable still off", drv_en, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R5 cleared in standby", fault, 1'b0);
    cyc(1'b1, 1'b1);

    // R6 timer discarded on leaving normal
    cycn(1'b0, 1'b1, T - 5);
    cycn(1'b0, 1'b0, 2);
    cycn(1'b0, 1'b1, 10);
    chk("R6 count discarded", fault, 1'b0);
    cyc(1'b1, 1'b1);
    cycn(1'b0, 1'b1, T);
    chk("R3 full window after restart", fault, 1'b1);
    cyc(1'b1, 1'b1);

    // Random runs around the limit, checked against the model every cycle
    seg = 0; rt = 1'b1; rn = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (seg == 0) begin
        rt = ~rt;
        seg = rt ? int'($urandom_range(1, 4)) : int'($urandom_range(1, 2 * T));
        if ($urandom_range(0, 9) == 0) rn = ~rn;
      end
      if ($urandom_range(0, 199) == 0) rn = ~rn;
      seg--;
      cyc(rt, rn);
      chk("R3 random fault vs model", fault, logic'(m_fault));
      chk("R1 random enable vs model", drv_en, logic'(exp_enable(norm, m_fault)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule